// File: doc/BRIEF.md
# Compact-ISA ALU with Flags

This unit performs the register-to-register arithmetic and logic operations of a 16-bit compressed instruction set that works on 32-bit registers. Each operation takes two operands: the current destination register value and the source register value. It also takes the incoming carry and overflow flags. It returns a result, a write-back enable and the new N, Z, C and V flags. Decode logic outside the unit gives it a 4-bit operation code and pulses `start`. The register file takes `result` when `wr_en` is high, and the status register takes the flags when `done` is high.

Most operations finish in the cycle in which they are started. Shifts by a register amount take one extra internal cycle. The multiply takes one to four extra cycles, depending on how many of the upper bytes of the multiplier operand only repeat its sign. While the unit is busy it holds its stored outcome steady and ignores new start requests.

Top module: `nalu_top`

## Requirements
- R1: The operation code encoding is 0 AND, 1 EOR, 2 LSL, 3 LSR, 4 ASR, 5 ADC, 6 SBC, 7 ROR, 8 TST, 9 NEG, 10 CMP, 11 CMN, 12 ORR, 13 MUL, 14 BIC, 15 MVN. AND/TST give a&b, EOR gives a^b, ORR gives a|b, BIC gives a&~b and MVN gives ~b. All of these pass C and V through unchanged.
- R2: `wr_en` is high only in a cycle where `done` is high. With `done`, it is high for every operation except TST, CMP and CMN.
- R3: When `done` is high, `flag_n` equals bit 31 of `result`, and `flag_z` is high exactly when `result` is zero.
- R4: ADC gives a+b+carry_in. SBC gives a-b-(1-carry_in), where carry_in acts as not-borrow. C is the carry out of the sum and V is signed overflow.
- R5: NEG gives 0-b. CMP computes a-b and CMN computes a+b. C and V are produced in the same way as for a subtract or an add.
- R6: LSL, LSR, ASR and ROR shift `opnd_a` by the amount in `opnd_b[7:0]`. For amounts from 1 to 31, C is the last bit shifted out (for ROR, bit 31 of the result). V is unchanged.
- R7: A shift amount of zero gives `opnd_a` and leaves C unchanged. LSL or LSR by exactly 32 gives 0, with C set to bit 0 (LSL) or bit 31 (LSR) of `opnd_a`. LSL or LSR by more than 32 gives 0 with C clear. ASR by 32 or more fills every bit with bit 31, and C takes bit 31. ROR uses the amount modulo 32, and a non-zero multiple of 32 gives `opnd_a` with C set to bit 31.
- R8: Every operation other than a shift or MUL raises `done` in its start cycle with `busy` low, and `busy` stays low.
- R9: A shift raises `busy` and `done` together in the cycle after the start, and `busy` falls in the cycle after that.
- R10: MUL gives the low 32 bits of a*b and leaves C and V unchanged. Its `done` comes m cycles after the start. m is 1 when `opnd_b[31:8]` is all zeros or all ones, 2 when `[31:16]` is, 3 when `[31:24]` is, and 4 otherwise.
- R11: A `start` during `busy` is ignored. The outcome that is running is delivered unchanged, and the unit goes idle after its `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin an operation (accepted only when idle) |
| opcode | input | 4 | Operation code |
| opnd_a | input | 32 | First operand, the destination register value |
| opnd_b | input | 32 | Second operand, the source register value (holds the shift amount or multiplier) |
| carry_in | input | 1 | Incoming C flag |
| ovf_in | input | 1 | Incoming V flag |
| busy | output | 1 | Extra internal cycles are in progress |
| done | output | 1 | Result and flags are valid this cycle |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Write the result back to the destination register |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
A wrong cycle counter shows up at the ports within one to four cycles of a shift or multiply start. It appears as `done` arriving one cycle early or late, or as `busy` staying high after `done`. A corrupted stored outcome register shows up as a wrong `result` or wrong flags in the `done` cycle of that same operation. The bench makes a `start` request while the unit is busy, so a counter that accepts it is seen straight away as an extra busy cycle. A wrong carry or shift path for the edge amounts 0, 32 and above 32 is seen in the `flag_c` value of the operation itself.

// File: rtl/nalu_pkg.sv
package nalu_pkg;

   typedef enum logic [3:0] {
      OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_LSL = 4'd2,  OP_LSR = 4'd3,
      OP_ASR = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_ROR = 4'd7,
      OP_TST = 4'd8,  OP_NEG = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
      OP_ORR = 4'd12, OP_MUL = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
   } alu_op_e;

   typedef enum logic [1:0] {
      SH_LL = 2'd0,
      SH_LR = 2'd1,
      SH_AR = 2'd2,
      SH_RR = 2'd3
   } shift_kind_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } flags_t;

   function automatic logic op_is_shift(alu_op_e op);
      return (op == OP_LSL) || (op == OP_LSR) || (op == OP_ASR) || (op == OP_ROR);
   endfunction

   function automatic logic op_is_compare(alu_op_e op);
      return (op == OP_TST) || (op == OP_CMP) || (op == OP_CMN);
   endfunction

   function automatic logic op_is_arith(alu_op_e op);
      return (op == OP_ADC) || (op == OP_SBC) || (op == OP_NEG) ||
             (op == OP_CMP) || (op == OP_CMN);
   endfunction

   function automatic shift_kind_e op_shift_kind(alu_op_e op);
      shift_kind_e k;
      case (op)
         OP_LSR:  k = SH_LR;
         OP_ASR:  k = SH_AR;
         OP_ROR:  k = SH_RR;
         default: k = SH_LL;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/nalu_addsub.sv
module nalu_addsub #(
   parameter int W = 32
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         ovf
);

   logic [W:0] wide;

   always_comb begin
      wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
      sum  = wide[W-1:0];
      cout = wide[W];
      ovf  = (x[W-1] == y[W-1]) && (wide[W-1] != x[W-1]);
   end

endmodule

// File: rtl/nalu_shifter.sv
module nalu_shifter
   import nalu_pkg::*;
#(
   parameter int W     = 32,
   parameter int AMT_W = 8
) (
   input  shift_kind_e      kind,
   input  logic [W-1:0]     value,
   input  logic [AMT_W-1:0] amount,
   input  logic             carry_in,
   output logic [W-1:0]     shifted,
   output logic             carry_out
);

   localparam int LW = $clog2(W);
   localparam logic [AMT_W-1:0] W_AMT = AMT_W'(W);

   initial begin
      assert ((1 << LW) == W) else $error("nalu_shifter: W must be a power of two");
      assert (W < (1 << AMT_W)) else $error("nalu_shifter: AMT_W too narrow for W");
   end

   logic [W:0]    ext;
   logic [LW-1:0] rot;

   always_comb begin
      shifted   = value;
      carry_out = carry_in;
      ext       = '0;
      rot       = amount[LW-1:0];
      if (amount != '0) begin
         unique case (kind)
            SH_LL: begin
               if (amount <= W_AMT) begin
                  ext       = {1'b0, value} << amount;
                  shifted   = ext[W-1:0];
                  carry_out = ext[W];
               end else begin
                  shifted   = '0;
                  carry_out = 1'b0;
               end
            end
            SH_LR: begin
               if (amount <= W_AMT) begin
                  ext       = {value, 1'b0} >> amount;
                  shifted   = ext[W:1];
                  carry_out = ext[0];
               end else begin
                  shifted   = '0;
                  carry_out = 1'b0;
               end
            end
            SH_AR: begin
               if (amount < W_AMT) begin
                  ext       = $signed({value, 1'b0}) >>> amount;
                  shifted   = ext[W:1];
                  carry_out = ext[0];
               end else begin
                  shifted   = {W{value[W-1]}};
                  carry_out = value[W-1];
               end
            end
            SH_RR: begin
               shifted   = W'({value, value} >> rot);
               carry_out = shifted[W-1];
            end
         endcase
      end
   end

endmodule

// File: rtl/nalu_mul_span.sv
module nalu_mul_span #(
   parameter int W     = 32,
   parameter int CNT_W = 3
) (
   input  logic [W-1:8]     upper,
   output logic [CNT_W-1:0] passes
);

   localparam int NB = W / 8;

   initial begin
      assert (W % 8 == 0 && W >= 16) else $error("nalu_mul_span: W must be a multiple of 8, at least 16");
      assert (NB < (1 << CNT_W)) else $error("nalu_mul_span: CNT_W too narrow");
   end

   logic [NB-1:1] uniform;

   for (genvar k = 1; k < NB; k++) begin : g_span
      assign uniform[k] = (&upper[W-1:8*k]) | ~(|upper[W-1:8*k]);
   end

   always_comb begin
      passes = CNT_W'(NB);
      for (int k = NB - 1; k >= 1; k--) begin
         if (uniform[k]) passes = CNT_W'(k);
      end
   end

endmodule

// File: rtl/nalu_seq.sv
module nalu_seq #(
   parameter int CNT_W = 3,
   parameter int PW    = 37
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] extra,
   input  logic [PW-1:0]    payload_in,
   output logic             busy,
   output logic             done,
   output logic [PW-1:0]    payload_q
);

   logic [CNT_W-1:0] cnt_q;
   logic             idle;
   logic             take;

   assign idle = (cnt_q == '0);
   assign take = start && idle;
   assign busy = !idle;
   assign done = (take && (extra == '0)) || (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         payload_q <= '0;
      end else if (take && (extra != '0)) begin
         cnt_q     <= extra;
         payload_q <= payload_in;
      end else if (!idle) begin
         cnt_q     <= cnt_q - CNT_W'(1);
      end
   end

   // R9 / R11: the last counted cycle hands control back, the next cycle is idle
   p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && done) |=> !busy);

   // R11: stored outcome cannot move while a counted operation is running
   p_payload_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> $stable(payload_q));

endmodule

// File: rtl/nalu_top.sv
module nalu_top
   import nalu_pkg::*;
#(
   parameter int W     = 32,
   parameter int AMT_W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [3:0]   opcode,
   input  logic [W-1:0] opnd_a,
   input  logic [W-1:0] opnd_b,
   input  logic         carry_in,
   input  logic         ovf_in,
   output logic         busy,
   output logic         done,
   output logic [W-1:0] result,
   output logic         wr_en,
   output logic         flag_n,
   output logic         flag_z,
   output logic         flag_c,
   output logic         flag_v
);

   localparam int NB    = W / 8;
   localparam int CNT_W = $clog2(NB + 1);
   localparam int PW    = W + 4 + 1;

   initial begin
      assert (W % 8 == 0 && W >= 16) else $error("nalu_top: W must be a multiple of 8, at least 16");
   end

   alu_op_e op;
   assign op = alu_op_e'(opcode);

   // adder operand routing
   logic [W-1:0] ax, ay, asum;
   logic         acin, acout, aovf;

   always_comb begin
      ax   = opnd_a;
      ay   = opnd_b;
      acin = carry_in;
      case (op)
         OP_SBC: ay = ~opnd_b;
         OP_NEG: begin ax = '0; ay = ~opnd_b; acin = 1'b1; end
         OP_CMP: begin ay = ~opnd_b; acin = 1'b1; end
         OP_CMN: acin = 1'b0;
         default: ;
      endcase
   end

   nalu_addsub #(.W(W)) i_addsub (
      .x(ax), .y(ay), .cin(acin), .sum(asum), .cout(acout), .ovf(aovf)
   );

   logic [W-1:0] sh_res;
   logic         sh_c;

   nalu_shifter #(.W(W), .AMT_W(AMT_W)) i_shifter (
      .kind(op_shift_kind(op)), .value(opnd_a), .amount(opnd_b[AMT_W-1:0]),
      .carry_in(carry_in), .shifted(sh_res), .carry_out(sh_c)
   );

   logic [CNT_W-1:0] mul_passes;

   nalu_mul_span #(.W(W), .CNT_W(CNT_W)) i_span (
      .upper(opnd_b[W-1:8]), .passes(mul_passes)
   );

   logic [W-1:0] prod;
   assign prod = opnd_a * opnd_b;

   // combinational outcome
   logic [W-1:0]     c_res;
   flags_t           c_flg;
   logic             c_wb;
   logic [CNT_W-1:0] c_extra;

   always_comb begin
      unique case (op)
         OP_AND, OP_TST: c_res = opnd_a & opnd_b;
         OP_EOR:         c_res = opnd_a ^ opnd_b;
         OP_ORR:         c_res = opnd_a | opnd_b;
         OP_BIC:         c_res = opnd_a & ~opnd_b;
         OP_MVN:         c_res = ~opnd_b;
         OP_MUL:         c_res = prod;
         OP_LSL, OP_LSR, OP_ASR, OP_ROR: c_res = sh_res;
         OP_ADC, OP_SBC, OP_NEG, OP_CMP, OP_CMN: c_res = asum;
      endcase

      c_flg.n = c_res[W-1];
      c_flg.z = (c_res == '0);
      c_flg.c = carry_in;
      c_flg.v = ovf_in;
      if (op_is_arith(op)) begin
         c_flg.c = acout;
         c_flg.v = aovf;
      end else if (op_is_shift(op)) begin
         c_flg.c = sh_c;
      end

      c_wb = !op_is_compare(op);

      if (op == OP_MUL)          c_extra = mul_passes;
      else if (op_is_shift(op))  c_extra = CNT_W'(1);
      else                       c_extra = '0;
   end

   logic [PW-1:0] pay_q;

   nalu_seq #(.CNT_W(CNT_W), .PW(PW)) i_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .extra(c_extra),
      .payload_in({c_res, c_flg, c_wb}),
      .busy(busy), .done(done), .payload_q(pay_q)
   );

   logic [W-1:0] o_res;
   flags_t       o_flg;
   logic         o_wb;

   always_comb begin
      if (busy) {o_res, o_flg, o_wb} = pay_q;
      else      {o_res, o_flg, o_wb} = {c_res, c_flg, c_wb};
   end

   assign result = o_res;
   assign flag_n = o_flg.n;
   assign flag_z = o_flg.z;
   assign flag_c = o_flg.c;
   assign flag_v = o_flg.v;
   assign wr_en  = done && o_wb;

   // R8: plain operations finish at once and leave the unit idle
   p_single_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !op_is_shift(op) && op != OP_MUL) |-> done ##1 !busy);

   // R9: register shifts cost exactly one extra cycle
   p_shift_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && op_is_shift(op)) |=> (busy && done));

   // R10: multiply always occupies at least one internal cycle
   p_mul_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && op == OP_MUL) |=> busy);

   // R11: outputs held while counting
   p_hold_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> ($stable(result) && $stable({flag_n, flag_z, flag_c, flag_v})));

   // R3: N and Z agree with the delivered result
   p_nz_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((flag_n == result[W-1]) && (flag_z == (result == '0))));

   // R2: compare-type operations never write back
   p_no_wb_compare_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && op_is_compare(op)) |-> !wr_en);

   // R2: write-back only together with done
   p_wb_with_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> done);

endmodule

// File: tb/test_nalu_top.sv
`timescale 1ns/1ps
module test_nalu_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  opcode = '0;
   logic [31:0] opnd_a = '0, opnd_b = '0;
   logic        carry_in = 1'b0, ovf_in = 1'b0;
   logic        busy, done, wr_en, flag_n, flag_z, flag_c, flag_v;
   logic [31:0] result;

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   nalu_top i_nalu_top (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in), .ovf_in(ovf_in),
      .busy(busy), .done(done), .result(result), .wr_en(wr_en),
      .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
   );

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // reference model written from the requirements
   task automatic ref_op(input int op, input logic [31:0] a, input logic [31:0] b,
                         input bit ci, input bit vi, output logic [31:0] r,
                         output bit c, output bit v, output bit wb, output int cyc);
      logic [32:0] t;
      logic [7:0]  amt;
      int          rr;
      amt = b[7:0];
      c = ci; v = vi; wb = 1; cyc = 0; r = '0;
      case (op)
         0, 8: r = a & b;
         1:    r = a ^ b;
         12:   r = a | b;
         14:   r = a & ~b;
         15:   r = ~b;
         5: begin t = {1'b0,a} + {1'b0,b} + 33'(ci); r = t[31:0]; c = t[32];
                  v = (a[31] == b[31]) && (r[31] != a[31]); end
         6, 9, 10: begin
            logic [31:0] x;
            logic        cc;
            x  = (op == 9) ? 32'd0 : a;
            cc = (op == 6) ? ci : 1'b1;
            t = {1'b0,x} + {1'b0,~b} + 33'(cc); r = t[31:0]; c = t[32];
            v = (x[31] != b[31]) && (r[31] != x[31]);
         end
         11: begin t = {1'b0,a} + {1'b0,b}; r = t[31:0]; c = t[32];
                   v = (a[31] == b[31]) && (r[31] != a[31]); end
         2, 3, 4, 7: begin
            cyc = 1;
            r = a;
            if (amt != 0) begin
               if (op == 2) begin
                  if (amt > 32) begin r = 0; c = 0; end
                  else begin t = {1'b0,a} << amt; r = t[31:0]; c = t[32]; end
               end else if (op == 3) begin
                  if (amt > 32) begin r = 0; c = 0; end
                  else begin t = {a,1'b0} >> amt; r = t[32:1]; c = t[0]; end
               end else if (op == 4) begin
                  if (amt >= 32) begin r = {32{a[31]}}; c = a[31]; end
                  else begin
                     r = a;
                     for (int i = 0; i < int'(amt); i++) begin c = r[0]; r = {r[31], r[31:1]}; end
                  end
               end else begin
                  rr = int'(amt) % 32;
                  r = a;
                  for (int i = 0; i < rr; i++) r = {r[0], r[31:1]};
                  c = r[31];
               end
            end
         end
         13: begin
            logic signed [31:0] sb;
            r  = a * b;
            sb = $signed(b);
            if (sb >= -256 && sb <= 255) cyc = 1;
            else if (sb >= -65536 && sb <= 65535) cyc = 2;
            else if (sb >= -16777216 && sb <= 16777215) cyc = 3;
            else cyc = 4;
         end
         default: ;
      endcase
      if (op == 8 || op == 10 || op == 11) wb = 0;
   endtask

   function automatic string tag_of(int op, logic [31:0] b);
      if (op == 0 || op == 1 || op == 8 || op == 12 || op == 14 || op == 15) return "R1";
      if (op == 5 || op == 6) return "R4";
      if (op == 9 || op == 10 || op == 11) return "R5";
      if (op == 13) return "R10";
      if (b[7:0] == 0 || b[7:0] >= 32) return "R7";
      return "R6";
   endfunction

   task automatic check_out(string tg, logic [31:0] er, bit ec, bit ev, bit ewb);
      chk(tg, "result", result, er);
      chk("R3", "nz", {30'd0, flag_n, flag_z}, {30'd0, er[31], er == 0});
      chk(tg, "cv", {30'd0, flag_c, flag_v}, {30'd0, ec, ev});
      chk("R2", "wr_en", 32'(wr_en), 32'(ewb));
   endtask

   task automatic run_op(int op, logic [31:0] a, logic [31:0] b, bit ci, bit vi, bit intrude);
      logic [31:0] er;
      bit ec, ev, ewb;
      int cyc;
      string tg, ttg;
      ref_op(op, a, b, ci, vi, er, ec, ev, ewb, cyc);
      tg  = tag_of(op, b);
      ttg = (cyc == 0) ? "R8" : (op == 13) ? "R10" : "R9";
      @(negedge clk);
      start = 1; opcode = 4'(op); opnd_a = a; opnd_b = b; carry_in = ci; ovf_in = vi;
      #1;
      if (cyc == 0) begin
         chk(ttg, "done/busy at start", {30'd0, done, busy}, 32'b10);
         check_out(tg, er, ec, ev, ewb);
         @(negedge clk);
         start = 0;
         #1;
         chk(ttg, "busy after single", 32'(busy), 32'd0);
      end else begin
         chk(ttg, "done/busy at start", {30'd0, done, busy}, 32'b00);
         for (int k = 1; k <= cyc; k++) begin
            @(negedge clk);
            if (intrude) begin
               start = 1; opcode = 4'd0; opnd_a = $urandom; opnd_b = $urandom;
               carry_in = ~ci; ovf_in = ~vi;
            end else begin
               start = 0;
            end
            #1;
            chk(ttg, "busy/done in count", {30'd0, busy, done}, {30'd0, 1'b1, k == cyc});
            if (k < cyc) chk("R2", "wr_en while counting", 32'(wr_en), 32'd0);
            else check_out(intrude ? "R11" : tg, er, ec, ev, ewb);
         end
         if (intrude) begin
            @(negedge clk);
            start = 0;
            #1;
            chk("R11", "idle after intrusion", {30'd0, busy, done}, 32'd0);
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R8 watchdog expired");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd20240619));
      repeat (3) @(negedge clk);
      #1;
      chk("R8", "reset busy/done", {30'd0, busy, done}, 32'd0);
      rst_n = 1;

      // R1 logic
      run_op(0, 32'hF0F0_1234, 32'h0FF0_FF00, 1, 1, 0);
      run_op(1, 32'hAAAA_5555, 32'hFFFF_0000, 0, 1, 0);
      run_op(12, 32'h0, 32'h0, 1, 0, 0);
      run_op(14, 32'hFFFF_FFFF, 32'h8000_0001, 0, 0, 0);
      run_op(15, 32'h1, 32'hFFFF_FFFF, 1, 1, 0);
      run_op(8, 32'h8000_0000, 32'h8000_0000, 0, 0, 0);
      // R4 arithmetic with carry
      run_op(5, 32'h7FFF_FFFF, 32'h0, 1, 0, 0);
      run_op(5, 32'hFFFF_FFFF, 32'h1, 0, 0, 0);
      run_op(6, 32'h5, 32'h5, 0, 0, 0);
      run_op(6, 32'h8000_0000, 32'h1, 1, 0, 0);
      // R5
      run_op(9, 32'h1234, 32'h0, 0, 1, 0);
      run_op(9, 32'h0, 32'h8000_0000, 0, 0, 0);
      run_op(10, 32'h3, 32'h7, 1, 1, 0);
      run_op(11, 32'h8000_0000, 32'h8000_0000, 0, 0, 0);
      // R6 / R7 shifts
      run_op(2, 32'h8000_0001, 32'd1, 0, 1, 0);
      run_op(3, 32'h8000_0001, 32'd31, 0, 0, 0);
      run_op(4, 32'h8000_0000, 32'd4, 0, 0, 0);
      run_op(7, 32'h0000_00F1, 32'd4, 0, 0, 0);
      run_op(2, 32'hDEAD_BEEF, 32'h100, 1, 0, 0);
      run_op(2, 32'h0000_0001, 32'd32, 0, 0, 0);
      run_op(3, 32'h8000_0000, 32'd32, 0, 0, 0);
      run_op(2, 32'hFFFF_FFFF, 32'd33, 1, 0, 0);
      run_op(3, 32'hFFFF_FFFF, 32'd255, 1, 0, 0);
      run_op(4, 32'h8000_0000, 32'd40, 0, 0, 0);
      run_op(4, 32'h7FFF_FFFF, 32'd32, 1, 0, 0);
      run_op(7, 32'h8000_1234, 32'd64, 0, 0, 0);
      run_op(7, 32'h0000_0001, 32'd33, 0, 0, 0);
      // R10 multiply spans
      run_op(13, 32'd7, 32'd9, 1, 1, 0);
      run_op(13, 32'h1234_5678, 32'hFFFF_FF80, 0, 0, 0);
      run_op(13, 32'h0000_0003, 32'h0000_1234, 0, 1, 0);
      run_op(13, 32'h0000_0003, 32'hFFFF_8000, 1, 0, 0);
      run_op(13, 32'h0001_0001, 32'h00AB_CDEF, 0, 0, 0);
      run_op(13, 32'hFFFF_FFFF, 32'h1234_5678, 1, 1, 0);
      run_op(13, 32'h0, 32'h8000_0000, 0, 0, 0);
      // R11 intrusion while busy
      run_op(13, 32'h0BAD_F00D, 32'h7654_3210, 1, 0, 1);
      run_op(13, 32'h0000_0011, 32'h0003_0000, 0, 1, 1);
      run_op(3, 32'hC000_0000, 32'd3, 1, 1, 1);

      // constrained random
      for (int i = 0; i < 600; i++) begin
         int op;
         logic [31:0] a, b;
         int sel;
         op  = int'($urandom_range(0, 15));
         a   = $urandom;
         b   = $urandom;
         sel = int'($urandom_range(0, 5));
         if (op == 13) begin
            case (sel)
               0: b = {{24{b[7]}}, b[7:0]};
               1: b = {{16{b[15]}}, b[15:0]};
               2: b = {{8{b[23]}}, b[23:0]};
               default: ;
            endcase
         end else if (op == 2 || op == 3 || op == 4 || op == 7) begin
            case (sel)
               0: b[7:0] = 8'd0;
               1: b[7:0] = 8'd32;
               2: b[7:0] = 8'(32 + $urandom_range(1, 200));
               default: b[7:0] = 8'($urandom_range(1, 31));
            endcase
         end else if (sel == 0) begin
            b = a;
         end
         run_op(op, a, b, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                $urandom_range(0, 9) == 0);
      end

      summary();
      $finish;
   end

endmodule